// File: doc/BRIEF.md
# Three-Channel Legacy DMA Register Window

This block holds the programming state of three emulated legacy DMA channels and exposes it to a system chipset through a 16-byte I/O window. Software places the window by setting a base field. Two address bits then pick one of the three channels through a sparse code. Within the window, each low address nibble is an offset with its own meaning. Writes land in the base registers. Reads of the same offsets return the live current address and current count.

A separate engine that moves the data reports each transferred unit on a per-channel step input. The block advances the current address, counts the current count down, and flags terminal count when the count wraps to all ones. A channel in auto-initialize mode then restarts from its base values. Shared state is kept alongside the channels: a group enable, one mask bit per channel and a sticky terminal-count status. An offset resets this shared state as a master clear. Configuration-space setup writes reach the block as one reload pulse per channel.

Top module: `dma_win_regs`

## Requirements
- R1: The window is hit only when address bits 31..16 are zero and bits 15..6 equal `win_base_i`. Bits 5..4 choose the channel: 00 gives index 0, 01 gives index 1, 11 gives index 2, and 10 matches nothing. A write that misses changes nothing, and a read that misses returns 00h.
- R2: `bus_rdata_o` is registered. In the cycle after a read strobe it carries the addressed byte. In the cycle after any clock without a read strobe it is 00h.
- R3: Writes to offsets 0h and 1h load bits 7..0 and 15..8 of the selected channel's base address. Reads of those offsets return the same bytes of the current address. Offset 2h reads and writes the channel's 8-bit page.
- R4: Writes to offsets 4h and 5h load the low and high bytes of the base count. Reads of those offsets return the low and high bytes of the current count.
- R5: A write to offset 0h, 1h, 4h or 5h reloads both current registers of that channel from its base registers, including the new byte. A pulse on `cfg_load_i[i]` does the same for channel index i. These reloads take priority over a step in the same cycle.
- R6: A step on `step_i[i]` is taken only when the group enable is 1, `mask_o[i]` is 0 and the current count is not FFFFh. A taken step adds one to the 16-bit current address and subtracts one from the current count. The page does not change.
- R7: `tc_o[i]` is high while the current count of channel i is FFFFh. When a taken step moves the count from 0000h to FFFFh, status bit i is set, and it stays set until a master clear. A read of offset 8h returns the status with bit i for channel index i and zeros above.
- R8: A write to offset Bh stores data bits 5..2 as the channel's 4-bit mode. Mode bit 2, which is data bit 4, selects auto-initialize. With that bit set, a channel whose count is FFFFh reloads both current registers from base on the next clock.
- R9: A write to offset 8h copies data bit 2 into `grp_en_o`. A write to offset Fh copies data bit 0 into the selected channel's `mask_o` bit. After reset all masks are 1 and the group enable is 0.
- R10: A write to offset Dh in any channel's window sets all three mask bits, clears the group enable and clears the status. It leaves the channel registers unchanged.
- R11: Writes to offset 9h and to the reserved offsets 3h, 6h, 7h, Ah, Ch and Eh change no state. Reads of any offset other than 0h, 1h, 2h, 4h, 5h and 8h return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_base_i | input | 10 | Window base, compared with address bits 15..6 |
| bus_addr_i | input | 32 | Register bus address |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| cfg_load_i | input | 3 | Per-channel reload pulse from configuration-space setup writes |
| step_i | input | 3 | Per-channel transfer-step pulse |
| tc_o | output | 3 | Per-channel terminal count |
| mask_o | output | 3 | Per-channel mask |
| grp_en_o | output | 1 | Group enable |

## Verification
The assertions assume that the bus never raises a write strobe and a read strobe in the same cycle. They also assume that each strobe describes exactly one access per cycle, with address and data steady across the clock edge. The bench drives every input just after a falling edge and holds it until the next one. It never sets both strobes together. Its random phase draws addresses that often miss on the base, mostly hit, and cover all four channel codes and all sixteen offsets. Master clears are made rare so that unmasked, enabled channels get steps often enough to reach terminal count and auto-reload.

// File: rtl/dma_win_pkg.sv
package dma_win_pkg;
  localparam int NCH      = 3;
  localparam int CNT_W    = 16;
  localparam int PAGE_W   = 8;
  localparam int BASE_W   = 10;
  localparam int MODE_W   = 4;
  localparam int AUTO_BIT = 2;
  localparam int BUS_AW   = 32;
  localparam int BYTE_W   = 8;

  typedef enum logic [3:0] {
    OFS_ADDR_LO = 4'h0,
    OFS_ADDR_HI = 4'h1,
    OFS_PAGE    = 4'h2,
    OFS_CNT_LO  = 4'h4,
    OFS_CNT_HI  = 4'h5,
    OFS_GROUP   = 4'h8,
    OFS_ABORT   = 4'h9,
    OFS_MODE    = 4'hB,
    OFS_CLEAR   = 4'hD,
    OFS_MASK    = 4'hF
  } ofs_e;
endpackage

// File: rtl/dma_win_decode.sv
module dma_win_decode
  import dma_win_pkg::*;
(
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [BASE_W-1:0] base_i,
  output logic              hit_o,
  output logic [NCH-1:0]    sel_o,
  output logic [3:0]        ofs_o
);
  logic base_ok;

  assign base_ok = (addr_i[BUS_AW-1:16] == '0) && (addr_i[15:6] == base_i);
  assign ofs_o   = addr_i[3:0];

  // sparse channel code: 10 is left undecoded
  always_comb begin
    sel_o = '0;
    if (base_ok) begin
      unique case (addr_i[5:4])
        2'b00:   sel_o[0] = 1'b1;
        2'b01:   sel_o[1] = 1'b1;
        2'b11:   sel_o[2] = 1'b1;
        default: sel_o = '0;
      endcase
    end
  end

  assign hit_o = |sel_o;
endmodule

// File: rtl/dma_win_chan.sv
module dma_win_chan
  import dma_win_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [3:0]        ofs_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              cfg_load_i,
  input  logic              step_en_i,
  output logic [CNT_W-1:0]  cur_addr_o,
  output logic [CNT_W-1:0]  cur_cnt_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              tc_o,
  output logic              tc_evt_o
);
  logic [CNT_W-1:0]  base_addr_q, base_cnt_q, cur_addr_q, cur_cnt_q;
  logic [CNT_W-1:0]  nxt_base_addr, nxt_base_cnt;
  logic [PAGE_W-1:0] page_q;
  logic [MODE_W-1:0] mode_q;
  logic              base_wr, reload, tc, auto_rl, stepping;

  always_comb begin
    nxt_base_addr = base_addr_q;
    nxt_base_cnt  = base_cnt_q;
    base_wr       = 1'b0;
    if (wr_i) begin
      case (ofs_i)
        OFS_ADDR_LO: begin nxt_base_addr[7:0]       = wdata_i; base_wr = 1'b1; end
        OFS_ADDR_HI: begin nxt_base_addr[CNT_W-1:8] = wdata_i; base_wr = 1'b1; end
        OFS_CNT_LO:  begin nxt_base_cnt[7:0]        = wdata_i; base_wr = 1'b1; end
        OFS_CNT_HI:  begin nxt_base_cnt[CNT_W-1:8]  = wdata_i; base_wr = 1'b1; end
        default: ;
      endcase
    end
  end

  assign tc       = (cur_cnt_q == '1);
  assign reload   = base_wr | cfg_load_i;
  assign auto_rl  = mode_q[AUTO_BIT] & tc;
  assign stepping = step_en_i & ~tc & ~reload & ~auto_rl;
  assign tc_evt_o = stepping & (cur_cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      cur_cnt_q   <= '0;
      page_q      <= '0;
      mode_q      <= '0;
    end else begin
      base_addr_q <= nxt_base_addr;
      base_cnt_q  <= nxt_base_cnt;
      if (wr_i && ofs_i == OFS_PAGE) page_q <= wdata_i;
      if (wr_i && ofs_i == OFS_MODE) mode_q <= wdata_i[MODE_W+1:2];
      if (reload) begin
        cur_addr_q <= nxt_base_addr;
        cur_cnt_q  <= nxt_base_cnt;
      end else if (auto_rl) begin
        cur_addr_q <= base_addr_q;
        cur_cnt_q  <= base_cnt_q;
      end else if (stepping) begin
        cur_addr_q <= cur_addr_q + 1'b1;
        cur_cnt_q  <= cur_cnt_q - 1'b1;
      end
    end
  end

  assign cur_addr_o = cur_addr_q;
  assign cur_cnt_o  = cur_cnt_q;
  assign page_o     = page_q;
  assign tc_o       = tc;
endmodule

// File: rtl/dma_win_ctrl.sv
module dma_win_ctrl
  import dma_win_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [3:0]     ofs_i,
  input  logic           grp_bit_i,
  input  logic           mask_bit_i,
  input  logic [NCH-1:0] sel_i,
  input  logic [NCH-1:0] tc_evt_i,
  output logic           grp_en_o,
  output logic [NCH-1:0] mask_o,
  output logic [NCH-1:0] sts_o
);
  logic clr;

  assign clr = wr_i && (ofs_i == OFS_CLEAR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_en_o <= 1'b0;
      mask_o   <= '1;
      sts_o    <= '0;
    end else if (clr) begin
      grp_en_o <= 1'b0;
      mask_o   <= '1;
      sts_o    <= '0;
    end else begin
      if (wr_i && ofs_i == OFS_GROUP) grp_en_o <= grp_bit_i;
      for (int i = 0; i < NCH; i++) begin
        if (wr_i && ofs_i == OFS_MASK && sel_i[i]) mask_o[i] <= mask_bit_i;
      end
      sts_o <= sts_o | tc_evt_i;
    end
  end
endmodule

// File: rtl/dma_win_regs.sv
module dma_win_regs
  import dma_win_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BASE_W-1:0] win_base_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  input  logic [NCH-1:0]    cfg_load_i,
  input  logic [NCH-1:0]    step_i,
  output logic [NCH-1:0]    tc_o,
  output logic [NCH-1:0]    mask_o,
  output logic              grp_en_o
);
  logic              win_hit;
  logic [NCH-1:0]    win_sel;
  logic [3:0]        win_ofs;
  logic [NCH-1:0]    tc_evt, sts;
  logic [CNT_W-1:0]  cur_addr [NCH];
  logic [CNT_W-1:0]  cur_cnt  [NCH];
  logic [PAGE_W-1:0] page     [NCH];
  logic [BYTE_W-1:0] rd_val;

  dma_win_decode u_dec (
    .addr_i (bus_addr_i),
    .base_i (win_base_i),
    .hit_o  (win_hit),
    .sel_o  (win_sel),
    .ofs_o  (win_ofs)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dma_win_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (bus_wr_i & win_sel[g]),
      .ofs_i      (win_ofs),
      .wdata_i    (bus_wdata_i),
      .cfg_load_i (cfg_load_i[g]),
      .step_en_i  (step_i[g] & grp_en_o & ~mask_o[g]),
      .cur_addr_o (cur_addr[g]),
      .cur_cnt_o  (cur_cnt[g]),
      .page_o     (page[g]),
      .tc_o       (tc_o[g]),
      .tc_evt_o   (tc_evt[g])
    );
  end

  dma_win_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (bus_wr_i & win_hit),
    .ofs_i      (win_ofs),
    .grp_bit_i  (bus_wdata_i[2]),
    .mask_bit_i (bus_wdata_i[0]),
    .sel_i      (win_sel),
    .tc_evt_i   (tc_evt),
    .grp_en_o   (grp_en_o),
    .mask_o     (mask_o),
    .sts_o      (sts)
  );

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NCH; i++) begin
      if (win_sel[i]) begin
        case (win_ofs)
          OFS_ADDR_LO: rd_val = cur_addr[i][7:0];
          OFS_ADDR_HI: rd_val = cur_addr[i][CNT_W-1:8];
          OFS_PAGE:    rd_val = page[i];
          OFS_CNT_LO:  rd_val = cur_cnt[i][7:0];
          OFS_CNT_HI:  rd_val = cur_cnt[i][CNT_W-1:8];
          OFS_GROUP:   rd_val = {{(BYTE_W-NCH){1'b0}}, sts};
          default:     rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 bus_rdata_o <= '0;
    else if (bus_rd_i && win_hit) bus_rdata_o <= rd_val;
    else                         bus_rdata_o <= '0;
  end
endmodule

// File: rtl/dma_win_regs_chk.sv
module dma_win_regs_chk
  import dma_win_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [BYTE_W-1:0] bus_wdata_i,
  input logic [BYTE_W-1:0] bus_rdata_o,
  input logic [NCH-1:0]    cfg_load_i,
  input logic [NCH-1:0]    step_i,
  input logic [NCH-1:0]    tc_o,
  input logic [NCH-1:0]    mask_o,
  input logic              grp_en_o,
  input logic              hit,
  input logic [NCH-1:0]    sel,
  input logic [3:0]        ofs
);
  logic rsvd_rd;
  assign rsvd_rd = !(ofs inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h5, 4'h8});

  a_r1_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));

  a_r1_miss_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && !hit) |=> (bus_rdata_o == '0));

  a_r2_idle_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> (bus_rdata_o == '0));

  a_r11_rsvd_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && hit && rsvd_rd) |=> (bus_rdata_o == '0));

  a_r11_abort_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && hit && ofs == 4'h9) |=> ($stable(mask_o) && $stable(grp_en_o)));

  a_r10_master_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && hit && ofs == 4'hD) |=> (mask_o == '1 && !grp_en_o));

  a_r9_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && sel[0] && ofs == 4'hF) |=> (mask_o[0] == $past(bus_wdata_i[0])));

  a_r9_group_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && hit && ofs == 4'h8) |=> (grp_en_o == $past(bus_wdata_i[2])));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // a masked channel with no reload cannot reach terminal count
    a_r6_masked_no_tc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_o[g] && !tc_o[g] && !bus_wr_i && !cfg_load_i[g]) |=> !tc_o[g]);
    a_r6_no_step_no_tc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!step_i[g] && !tc_o[g] && !bus_wr_i && !cfg_load_i[g]) |=> !tc_o[g]);
  end
endmodule

bind dma_win_regs dma_win_regs_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_wr_i    (bus_wr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .cfg_load_i  (cfg_load_i),
  .step_i      (step_i),
  .tc_o        (tc_o),
  .mask_o      (mask_o),
  .grp_en_o    (grp_en_o),
  .hit         (win_hit),
  .sel         (win_sel),
  .ofs         (win_ofs)
);

// File: tb/dma_win_regs_test.sv
module dma_win_regs_test;
  localparam int CLK_P = 10;
  localparam logic [9:0] BASE = 10'h2C5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] bus_addr_i = '0;
  logic        bus_wr_i = 1'b0, bus_rd_i = 1'b0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic [2:0]  cfg_load_i = '0, step_i = '0;
  logic [2:0]  tc_o, mask_o;
  logic        grp_en_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0, live = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  dma_win_regs uut (
    .clk_i, .rst_ni, .win_base_i(BASE), .bus_addr_i, .bus_wr_i, .bus_rd_i,
    .bus_wdata_i, .bus_rdata_o, .cfg_load_i, .step_i, .tc_o, .mask_o, .grp_en_o
  );

  // ---------------- reference model ----------------
  logic [15:0] m_ba[3], m_ca[3], m_bc[3], m_cc[3];
  logic [7:0]  m_pg[3];
  logic [3:0]  m_md[3];
  logic [2:0]  m_mask, m_sts, m_gate, m_evt;
  logic        m_grp, m_rl;
  logic [7:0]  m_rd, m_v, m_d;
  logic [3:0]  m_o;
  int          m_ch;

  function automatic int dec(logic [31:0] a);
    if (a[31:16] != 0 || a[15:6] != BASE) return -1;
    case (a[5:4])
      2'd0: return 0;
      2'd1: return 1;
      2'd3: return 2;
      default: return -1;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 3; i++) begin
        m_ba[i] = 0; m_ca[i] = 0; m_bc[i] = 0; m_cc[i] = 0; m_pg[i] = 0; m_md[i] = 0;
      end
      m_mask = 3'b111; m_sts = 0; m_grp = 0; m_rd = 0;
    end else begin
      m_ch = dec(bus_addr_i); m_o = bus_addr_i[3:0]; m_d = bus_wdata_i; m_v = 0;
      if (bus_rd_i && m_ch >= 0) begin
        case (m_o)
          4'h0: m_v = m_ca[m_ch][7:0];
          4'h1: m_v = m_ca[m_ch][15:8];
          4'h2: m_v = m_pg[m_ch];
          4'h4: m_v = m_cc[m_ch][7:0];
          4'h5: m_v = m_cc[m_ch][15:8];
          4'h8: m_v = {5'b0, m_sts};
          default: m_v = 0;
        endcase
      end
      m_rd = m_v;
      m_evt = 0;
      for (int i = 0; i < 3; i++) m_gate[i] = m_grp && !m_mask[i];
      for (int i = 0; i < 3; i++) begin
        m_rl = cfg_load_i[i];
        if (bus_wr_i && m_ch == i) begin
          case (m_o)
            4'h0: begin m_ba[i][7:0] = m_d;  m_rl = 1; end
            4'h1: begin m_ba[i][15:8] = m_d; m_rl = 1; end
            4'h4: begin m_bc[i][7:0] = m_d;  m_rl = 1; end
            4'h5: begin m_bc[i][15:8] = m_d; m_rl = 1; end
            4'h2: m_pg[i] = m_d;
            4'hB: m_md[i] = m_d[5:2];
            default: ;
          endcase
        end
        if (m_rl || (m_md[i][2] && m_cc[i] == 16'hFFFF)) begin
          m_ca[i] = m_ba[i]; m_cc[i] = m_bc[i];
        end else if (step_i[i] && m_gate[i] && m_cc[i] != 16'hFFFF) begin
          if (m_cc[i] == 0) m_evt[i] = 1;
          m_ca[i] = m_ca[i] + 1; m_cc[i] = m_cc[i] - 1;
        end
      end
      if (bus_wr_i && m_ch >= 0 && m_o == 4'hD) begin
        m_mask = 3'b111; m_grp = 0; m_sts = 0;
      end else begin
        if (bus_wr_i && m_ch >= 0 && m_o == 4'h8) m_grp = m_d[2];
        if (bus_wr_i && m_ch >= 0 && m_o == 4'hF) m_mask[m_ch] = m_d[0];
        m_sts = m_sts | m_evt;
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk_i) begin
    if (live && rst_ni) begin
      n_vec++;
      if (bus_rdata_o !== m_rd) begin
        n_bad++; $display("FAIL R2 rdata act=%h exp=%h", bus_rdata_o, m_rd);
      end
      for (int i = 0; i < 3; i++)
        if (tc_o[i] !== (m_cc[i] == 16'hFFFF)) begin
          n_bad++; $display("FAIL R7 tc[%0d] act=%b exp=%b", i, tc_o[i], m_cc[i] == 16'hFFFF);
        end
      if (mask_o !== m_mask || grp_en_o !== m_grp) begin
        n_bad++; $display("FAIL R9 mask/grp act=%b/%b exp=%b/%b", mask_o, grp_en_o, m_mask, m_grp);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++; $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wa(logic [1:0] code, logic [3:0] ofs);
    return {16'h0, BASE, code, ofs};
  endfunction

  task automatic wr(logic [31:0] a, logic [7:0] d);
    @(negedge clk_i); bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1;
    @(negedge clk_i); bus_wr_i = 0;
  endtask

  task automatic rd(logic [31:0] a, output logic [7:0] d);
    @(negedge clk_i); bus_addr_i = a; bus_rd_i = 1;
    @(negedge clk_i); d = bus_rdata_o; bus_rd_i = 0;
  endtask

  task automatic steps(int ch, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i); step_i[ch] = 1;
    end
    @(negedge clk_i); step_i = 0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_bad++; $display("FAIL watchdog act=running exp=done");
      summary();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk_i);
    chk("R9 reset mask", {13'b0, mask_o}, 16'h7);
    chk("R9 reset grp", {15'b0, grp_en_o}, 16'h0);
    chk("R7 reset tc", {13'b0, tc_o}, 16'h0);
    chk("R2 reset rdata", {8'b0, bus_rdata_o}, 16'h0);
    rst_ni = 1; live = 1;

    // R3 R4 R5: program channel index 0
    wr(wa(2'b00, 4'h0), 8'h34); wr(wa(2'b00, 4'h1), 8'h12);
    wr(wa(2'b00, 4'h2), 8'h56);
    wr(wa(2'b00, 4'h4), 8'h03); wr(wa(2'b00, 4'h5), 8'h00);
    rd(wa(2'b00, 4'h0), d); chk("R3 addr lo", d, 8'h34);
    rd(wa(2'b00, 4'h1), d); chk("R3 addr hi", d, 8'h12);
    rd(wa(2'b00, 4'h2), d); chk("R3 page", d, 8'h56);
    rd(wa(2'b00, 4'h4), d); chk("R4 cnt lo", d, 8'h03);
    rd(wa(2'b00, 4'h5), d); chk("R5 cnt hi reload", d, 8'h00);
    @(negedge clk_i); chk("R2 idle after read", bus_rdata_o, 8'h00);

    // R9: group enable and unmask
    wr(wa(2'b00, 4'h8), 8'h04); wr(wa(2'b00, 4'hF), 8'h00);
    chk("R9 group", grp_en_o, 1'b1);
    chk("R9 mask ch0", mask_o, 3'b110);

    // R6 R7: count 3 down to FFFF
    steps(0, 4);
    chk("R7 tc ch0", tc_o, 3'b001);
    rd(wa(2'b00, 4'h0), d); chk("R6 addr advanced", d, 8'h38);
    rd(wa(2'b00, 4'h2), d); chk("R6 page unchanged", d, 8'h56);
    rd(wa(2'b00, 4'h8), d); chk("R7 status", d, 8'h01);
    steps(0, 2);
    rd(wa(2'b00, 4'h0), d); chk("R6 no step past tc", d, 8'h38);

    // R8: auto-initialize on channel index 1
    wr(wa(2'b01, 4'h0), 8'h00); wr(wa(2'b01, 4'h1), 8'h20);
    wr(wa(2'b01, 4'h4), 8'h01); wr(wa(2'b01, 4'h5), 8'h00);
    wr(wa(2'b01, 4'hB), 8'h10); wr(wa(2'b01, 4'hF), 8'h00);
    @(negedge clk_i); step_i[1] = 1;
    @(negedge clk_i);
    @(negedge clk_i); step_i = 0;
    chk("R8 tc before reload", tc_o, 3'b011);
    @(negedge clk_i);
    chk("R8 tc after reload", tc_o[1], 1'b0);
    rd(wa(2'b01, 4'h4), d); chk("R8 count reloaded", d, 8'h01);
    rd(wa(2'b01, 4'h0), d); chk("R8 addr reloaded", d, 8'h00);
    rd(wa(2'b01, 4'h8), d); chk("R7 status two", d, 8'h03);

    // R1: sparse code and base match
    wr(wa(2'b11, 4'h0), 8'hAB);
    rd(wa(2'b11, 4'h0), d); chk("R1 code 11", d, 8'hAB);
    wr(wa(2'b10, 4'h2), 8'h77);
    rd(wa(2'b10, 4'h2), d); chk("R1 code 10 miss", d, 8'h00);
    rd({16'h0, BASE ^ 10'h001, 2'b00, 4'h0}, d); chk("R1 base miss read", d, 8'h00);
    wr({16'h0, BASE ^ 10'h001, 2'b00, 4'h2}, 8'hEE);
    wr({16'h1, BASE, 2'b00, 4'h2}, 8'hEE);
    rd(wa(2'b00, 4'h2), d); chk("R1 miss write ignored", d, 8'h56);

    // R5: configuration reload on channel index 2
    wr(wa(2'b11, 4'h4), 8'h10); wr(wa(2'b11, 4'h5), 8'h00);
    wr(wa(2'b11, 4'hF), 8'h00);
    steps(2, 3);
    rd(wa(2'b11, 4'h4), d); chk("R6 ch2 count", d, 8'h0D);
    @(negedge clk_i); cfg_load_i = 3'b100;
    @(negedge clk_i); cfg_load_i = 0;
    rd(wa(2'b11, 4'h4), d); chk("R5 cfg reload", d, 8'h10);

    // R11: abort and reserved offsets
    wr(wa(2'b00, 4'h9), 8'hFF);
    foreach (d[k]) ;
    wr(wa(2'b00, 4'h3), 8'hFF); wr(wa(2'b00, 4'h6), 8'hFF); wr(wa(2'b00, 4'h7), 8'hFF);
    wr(wa(2'b00, 4'hA), 8'hFF); wr(wa(2'b00, 4'hC), 8'hFF); wr(wa(2'b00, 4'hE), 8'hFF);
    chk("R11 mask kept", mask_o, 3'b000);
    chk("R11 group kept", grp_en_o, 1'b1);
    rd(wa(2'b00, 4'h2), d); chk("R11 page kept", d, 8'h56);
    rd(wa(2'b00, 4'h0), d); chk("R11 addr kept", d, 8'h38);
    rd(wa(2'b00, 4'h3), d); chk("R11 reserved read", d, 8'h00);
    rd(wa(2'b00, 4'hB), d); chk("R11 mode read", d, 8'h00);

    // R10: master clear
    wr(wa(2'b01, 4'hD), 8'h00);
    chk("R10 masks set", mask_o, 3'b111);
    chk("R10 group clear", grp_en_o, 1'b0);
    rd(wa(2'b00, 4'h8), d); chk("R10 status clear", d, 8'h00);
    rd(wa(2'b00, 4'h0), d); chk("R10 channel kept", d, 8'h38);

    // random phase, model compared on every clock
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [3:0] o;
      @(negedge clk_i);
      r = $urandom % 100;
      o = 4'($urandom);
      if (o == 4'hD && ($urandom % 8) != 0) o = 4'hF;
      bus_addr_i = (($urandom % 16) == 0) ? {16'h0, 10'($urandom), 2'($urandom), o}
                                          : wa(2'($urandom), o);
      bus_wdata_i = 8'($urandom);
      bus_wr_i = (r < 35);
      bus_rd_i = (r >= 35 && r < 70);
      step_i = 3'($urandom);
      cfg_load_i = (($urandom % 20) == 0) ? 3'($urandom) : 3'b000;
    end
    @(negedge clk_i); bus_wr_i = 0; bus_rd_i = 0; step_i = 0; cfg_load_i = 0;
    repeat (3) @(negedge clk_i);
    done = 1;
    summary();
  end
endmodule